// File: doc/BRIEF.md
# Call Gate Transfer Sequencer

This block performs the descriptor work behind a far call that goes through a call gate. On a start request it takes the caller's selector and privilege level. It reads the two 32-bit words of the gate entry that the selector names and checks that entry. It then reads the two words of the destination code segment descriptor named by the gate's selector, and checks that descriptor too. The result is either a completion pulse that carries the new code selector, the new 32-bit linear entry address and the new privilege level, or a fault pulse that carries a reason code.

Descriptor reads go through a simple 32-bit read port. The block holds a request with a stable address until the memory side returns a one-cycle valid. The block never sees an instruction offset: the destination offset always comes from the gate. Stack switching and the return path are handled elsewhere.

Top module: `call_gate_seq`

## Requirements
- R1: A selector picks a table by bit 2 (0 selects `gdt_base`, 1 selects `ldt_base`) and an entry by bits 15:3. The entry address is base + index*8. Word 0 is read at that address and word 1 at address+4, in that order. `rd_req` stays high with `rd_addr` unchanged until `rd_valid` is seen.
- R2: Every entry carries present in word 1 bit 15, DPL in word 1 bits 14:13 and kind in word 1 bits 12:10. In a gate entry, word 0 is the destination offset and word 1 bits 31:16 are the destination selector. That selector is the one used to fetch the second descriptor. In a code descriptor, word 0 is the segment base.
- R3: A gate entry whose kind is not 3'b101 ends the call with fault code 1. The gate checks run in the order kind, then present, then privilege, and the first failure sets the code.
- R4: A gate entry with the present bit clear ends the call with fault code 2.
- R5: The caller's effective level is the larger of `cpl` and bits 1:0 of `call_sel`. If it is numerically greater than the gate DPL, the call ends with fault code 3.
- R6: A destination whose kind is not 3'b010 (code segment) ends with fault code 4. A destination that is not present ends with fault code 5. The kind check comes first.
- R7: If the destination DPL is numerically greater than `cpl`, the call ends with fault code 6.
- R8: The entry address is the destination base plus the gate offset, modulo 2^32.
- R9: On success, `done` is high for exactly one cycle. In that cycle `new_cpl` equals the destination DPL, and `new_sel` equals the gate's destination selector with bits 1:0 replaced by that DPL.
- R10: On any failure, `fault` is high for exactly one cycle with `fault_code` set, and no `done` pulse follows. `done` and `fault` are never high together.
- R11: `start` is accepted only while idle. `busy` is high from the cycle after an accepted start through the pulse cycle. A start while busy has no effect.
- R12: After reset, `busy`, `done`, `fault` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a gated call (sampled while idle) |
| call_sel | input | 16 | Selector from the call, naming the gate |
| cpl | input | 2 | Current privilege level of the caller |
| gdt_base | input | 32 | Base address of the global descriptor table |
| ldt_base | input | 32 | Base address of the local descriptor table |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_valid | input | 1 | One-cycle strobe: `rd_data` holds the requested word |
| rd_data | input | 32 | Returned descriptor word |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle failure pulse |
| fault_code | output | 3 | Failure reason, valid with `fault` |
| new_sel | output | 16 | New code selector, valid with `done` |
| new_eip | output | 32 | New linear entry address, valid with `done` |
| new_cpl | output | 2 | New privilege level, valid with `done` |

## Verification
The assertions assume that the memory side raises `rd_valid` only while `rd_req` is high. They also assume it raises it for exactly one cycle per word and never in the cycle straight after a previous strobe. The bench memory model answers only when it sees a request with no strobe pending, after a programmable delay of zero or more cycles, so it stays within that contract. The assertions also take `cpl` and the table bases as stable while busy, and the bench changes them only between transfers.

// File: rtl/cg_pkg.sv
package cg_pkg;

    localparam int PL_W   = 2;
    localparam int ATTR_W = 6;
    localparam int ATTR_LO = 10;

    localparam logic [2:0] KIND_GATE = 3'b101;
    localparam logic [2:0] KIND_CODE = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_GATE,
        ST_CHECK_GATE,
        ST_FETCH_TGT,
        ST_CHECK_TGT,
        ST_DONE,
        ST_FAULT
    } st_e;

    typedef enum logic [2:0] {
        FLT_NONE         = 3'd0,
        FLT_NOT_GATE     = 3'd1,
        FLT_GATE_ABSENT  = 3'd2,
        FLT_GATE_PRIV    = 3'd3,
        FLT_TGT_NOT_CODE = 3'd4,
        FLT_TGT_ABSENT   = 3'd5,
        FLT_TGT_PRIV     = 3'd6
    } flt_e;

endpackage

// File: rtl/cg_addr_gen.sv
module cg_addr_gen #(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [SEL_W-1:cg_pkg::PL_W] sel_hi,
    input  logic                        word_idx,
    input  logic [WORD_W-1:0]           gbase,
    input  logic [WORD_W-1:0]           lbase,
    output logic [WORD_W-1:0]           addr
);
    localparam int TI_POS  = cg_pkg::PL_W;
    localparam int IDX_LO  = TI_POS + 1;
    localparam int ENTRY_SH = 3;
    localparam int WORD_BYTES = WORD_W / 8;

    logic [WORD_W-1:0] base;
    logic [WORD_W-1:0] offs;

    always_comb begin
        base = sel_hi[TI_POS] ? lbase : gbase;
        offs = WORD_W'(sel_hi[SEL_W-1:IDX_LO]) << ENTRY_SH;
        addr = base + offs + (word_idx ? WORD_W'(WORD_BYTES) : '0);
    end
endmodule

// File: rtl/cg_desc_check.sv
module cg_desc_check #(
    parameter bit TARGET = 1'b0
) (
    input  logic [cg_pkg::ATTR_W-1:0] attr,
    input  logic [cg_pkg::PL_W-1:0]   pl,
    output cg_pkg::flt_e              code
);
    import cg_pkg::*;

    logic             present;
    logic [PL_W-1:0]  dpl;
    logic [2:0]       kind;

    always_comb begin
        present = attr[5];
        dpl     = attr[4:3];
        kind    = attr[2:0];
    end

    generate
        if (TARGET == 1'b0) begin : g_gate
            always_comb begin
                if (kind != KIND_GATE)  code = FLT_NOT_GATE;
                else if (!present)      code = FLT_GATE_ABSENT;
                else if (pl > dpl)      code = FLT_GATE_PRIV;
                else                    code = FLT_NONE;
            end
        end else begin : g_target
            always_comb begin
                if (kind != KIND_CODE)  code = FLT_TGT_NOT_CODE;
                else if (!present)      code = FLT_TGT_ABSENT;
                else if (dpl > pl)      code = FLT_TGT_PRIV;
                else                    code = FLT_NONE;
            end
        end
    endgenerate
endmodule

// File: rtl/cg_seq.sv
module cg_seq #(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [SEL_W-1:0]            call_sel,
    input  logic [cg_pkg::PL_W-1:0]     cpl,
    input  logic                        rd_valid,
    input  logic [WORD_W-1:0]           rd_data,
    input  cg_pkg::flt_e                flt_gate,
    input  cg_pkg::flt_e                flt_tgt,
    output logic [SEL_W-1:cg_pkg::PL_W] fetch_sel,
    output logic                        word_idx,
    output logic                        rd_req,
    output logic [cg_pkg::ATTR_W-1:0]   attr,
    output logic [cg_pkg::PL_W-1:0]     eff_pl,
    output logic [cg_pkg::PL_W-1:0]     caller_pl,
    output logic                        busy,
    output logic                        done,
    output logic                        fault,
    output logic [2:0]                  fault_code,
    output logic [SEL_W-1:0]            new_sel,
    output logic [WORD_W-1:0]           new_eip,
    output logic [cg_pkg::PL_W-1:0]     new_cpl
);
    import cg_pkg::*;

    localparam int SEL_HI_LO = 16 + PL_W;

    typedef struct packed {
        st_e                 st;
        logic                word;
        logic [SEL_W-1:PL_W] sel;
        logic [PL_W-1:0]     cpl;
        logic [PL_W-1:0]     eff;
        logic [WORD_W-1:0]   gate_off;
        logic [ATTR_W-1:0]   attr;
        logic [SEL_W-1:0]    new_sel;
        logic [WORD_W-1:0]   new_eip;
        logic [PL_W-1:0]     new_cpl;
        flt_e                code;
    } seq_t;

    seq_t s_d, s_q;
    logic [PL_W-1:0] rpl_in;
    logic [PL_W-1:0] tgt_dpl;

    always_comb begin
        s_d     = s_q;
        rpl_in  = call_sel[PL_W-1:0];
        tgt_dpl = s_q.attr[4:3];
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st   = ST_FETCH_GATE;
                    s_d.word = 1'b0;
                    s_d.sel  = call_sel[SEL_W-1:PL_W];
                    s_d.cpl  = cpl;
                    s_d.eff  = (rpl_in > cpl) ? rpl_in : cpl;
                    s_d.code = FLT_NONE;
                end
            end
            ST_FETCH_GATE: begin
                if (rd_valid) begin
                    if (!s_q.word) begin
                        s_d.gate_off = rd_data;
                        s_d.word     = 1'b1;
                    end else begin
                        s_d.attr = rd_data[ATTR_LO +: ATTR_W];
                        s_d.sel  = rd_data[WORD_W-1:SEL_HI_LO];
                        s_d.word = 1'b0;
                        s_d.st   = ST_CHECK_GATE;
                    end
                end
            end
            ST_CHECK_GATE: begin
                if (flt_gate != FLT_NONE) begin
                    s_d.code = flt_gate;
                    s_d.st   = ST_FAULT;
                end else begin
                    s_d.st   = ST_FETCH_TGT;
                end
            end
            ST_FETCH_TGT: begin
                if (rd_valid) begin
                    if (!s_q.word) begin
                        s_d.new_eip = rd_data + s_q.gate_off;
                        s_d.word    = 1'b1;
                    end else begin
                        s_d.attr = rd_data[ATTR_LO +: ATTR_W];
                        s_d.word = 1'b0;
                        s_d.st   = ST_CHECK_TGT;
                    end
                end
            end
            ST_CHECK_TGT: begin
                if (flt_tgt != FLT_NONE) begin
                    s_d.code = flt_tgt;
                    s_d.st   = ST_FAULT;
                end else begin
                    s_d.new_sel = {s_q.sel, tgt_dpl};
                    s_d.new_cpl = tgt_dpl;
                    s_d.st      = ST_DONE;
                end
            end
            ST_DONE:  s_d.st = ST_IDLE;
            ST_FAULT: s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        fetch_sel  = s_q.sel;
        word_idx   = s_q.word;
        rd_req     = (s_q.st == ST_FETCH_GATE) || (s_q.st == ST_FETCH_TGT);
        attr       = s_q.attr;
        eff_pl     = s_q.eff;
        caller_pl  = s_q.cpl;
        busy       = (s_q.st != ST_IDLE);
        done       = (s_q.st == ST_DONE);
        fault      = (s_q.st == ST_FAULT);
        fault_code = s_q.code;
        new_sel    = s_q.new_sel;
        new_eip    = s_q.new_eip;
        new_cpl    = s_q.new_cpl;
    end

    // R10: success and failure pulses exclude each other
    a_r10_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R9: success pulse lasts one cycle and returns to idle
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R10: a fault pulse carries a nonzero code and lasts one cycle
    a_r10_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 3'd0) ##1 !fault);

    // R7: new level never less privileged than the caller
    a_r7_cpl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> new_cpl <= caller_pl);

    // R11: reads only happen during a transfer
    a_r11_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);
endmodule

// File: rtl/call_gate_seq.sv
module call_gate_seq #(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [SEL_W-1:0]        call_sel,
    input  logic [cg_pkg::PL_W-1:0] cpl,
    input  logic [WORD_W-1:0]       gdt_base,
    input  logic [WORD_W-1:0]       ldt_base,
    output logic                    rd_req,
    output logic [WORD_W-1:0]       rd_addr,
    input  logic                    rd_valid,
    input  logic [WORD_W-1:0]       rd_data,
    output logic                    busy,
    output logic                    done,
    output logic                    fault,
    output logic [2:0]              fault_code,
    output logic [SEL_W-1:0]        new_sel,
    output logic [WORD_W-1:0]       new_eip,
    output logic [cg_pkg::PL_W-1:0] new_cpl
);
    import cg_pkg::*;

    logic [SEL_W-1:PL_W] fetch_sel;
    logic                word_idx;
    logic [ATTR_W-1:0]   attr;
    logic [PL_W-1:0]     eff_pl;
    logic [PL_W-1:0]     caller_pl;
    flt_e                flt_gate;
    flt_e                flt_tgt;

    cg_seq #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .call_sel   (call_sel),
        .cpl        (cpl),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .flt_gate   (flt_gate),
        .flt_tgt    (flt_tgt),
        .fetch_sel  (fetch_sel),
        .word_idx   (word_idx),
        .rd_req     (rd_req),
        .attr       (attr),
        .eff_pl     (eff_pl),
        .caller_pl  (caller_pl),
        .busy       (busy),
        .done       (done),
        .fault      (fault),
        .fault_code (fault_code),
        .new_sel    (new_sel),
        .new_eip    (new_eip),
        .new_cpl    (new_cpl)
    );

    cg_addr_gen #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_addr (
        .sel_hi   (fetch_sel),
        .word_idx (word_idx),
        .gbase    (gdt_base),
        .lbase    (ldt_base),
        .addr     (rd_addr)
    );

    cg_desc_check #(.TARGET(1'b0)) u_chk_gate (
        .attr (attr),
        .pl   (eff_pl),
        .code (flt_gate)
    );

    cg_desc_check #(.TARGET(1'b1)) u_chk_tgt (
        .attr (attr),
        .pl   (caller_pl),
        .code (flt_tgt)
    );

    // R1: a pending read keeps its request and address until answered
    a_r1_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> rd_req && $stable(rd_addr));
endmodule

// File: tb/call_gate_seq_tb.sv
module call_gate_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] call_sel;
    logic [1:0]  cpl;
    logic [31:0] gdt_base;
    logic [31:0] ldt_base;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        busy, done, fault;
    logic [2:0]  fault_code;
    logic [15:0] new_sel;
    logic [31:0] new_eip;
    logic [1:0]  new_cpl;

    always #4 clk = ~clk;

    call_gate_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .call_sel(call_sel), .cpl(cpl),
        .gdt_base(gdt_base), .ldt_base(ldt_base), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .fault(fault),
        .fault_code(fault_code), .new_sel(new_sel), .new_eip(new_eip), .new_cpl(new_cpl)
    );

    typedef struct packed {
        logic        is_fault;
        logic [2:0]  code;
        logic [15:0] sel;
        logic [31:0] eip;
        logic [1:0]  cpl;
        logic [23:0] tag;
    } exp_t;

    exp_t        exp_q[$];
    int          errors = 0;
    int          checks = 0;
    int          lat = 0;
    int          cnt = 0;
    logic [31:0] mem [logic [31:0]];

    localparam logic [31:0] GB = 32'h0001_0000;
    localparam logic [31:0] LB = 32'h0002_0000;

    task automatic chk(input bit ok, input logic [23:0] tag, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] hi_word(input logic [15:0] s, input logic p,
                                            input logic [1:0] d, input logic [2:0] k);
        return {s, p, d, k, 10'b0};
    endfunction

    function automatic logic [31:0] ent_addr(input logic [15:0] s);
        return (s[2] ? LB : GB) + {16'b0, s[15:3], 3'b0};
    endfunction

    task automatic put(input logic [15:0] s, input logic [31:0] w0, input logic [31:0] w1);
        mem[ent_addr(s)]     = w0;
        mem[ent_addr(s) + 4] = w1;
    endtask

    // memory model: answers a pending request after lat cycles
    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (rd_req && !rd_valid) begin
            if (cnt >= lat) begin
                rd_valid <= 1'b1;
                rd_data  <= mem.exists(rd_addr) ? mem[rd_addr] : 32'h0;
                cnt      <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // monitor: pops one expected item per result pulse
    always @(negedge clk) begin
        if (rst_n && (done || fault)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", {31'b0, done}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(done == !e.is_fault, e.tag, {31'b0, done}, {31'b0, !e.is_fault});
                chk(fault == e.is_fault, "R10", {31'b0, fault}, {31'b0, e.is_fault});
                if (e.is_fault) begin
                    chk(fault_code == e.code, e.tag, {29'b0, fault_code}, {29'b0, e.code});
                end else begin
                    chk(new_eip == e.eip, "R8", new_eip, e.eip);
                    chk(new_sel == e.sel, "R9", {16'b0, new_sel}, {16'b0, e.sel});
                    chk(new_cpl == e.cpl, "R9", {30'b0, new_cpl}, {30'b0, e.cpl});
                end
            end
        end
    end

    task automatic run(input logic [15:0] s, input logic [1:0] pl, input exp_t e);
        exp_q.push_back(e);
        @(negedge clk);
        call_sel = s;
        cpl      = pl;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11", {31'b0, busy}, 32'h1);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    function automatic exp_t ok_item(input logic [15:0] s, input logic [31:0] eip,
                                     input logic [1:0] pl, input logic [23:0] tag);
        exp_t e;
        e = '{is_fault: 1'b0, code: 3'd0, sel: s, eip: eip, cpl: pl, tag: tag};
        return e;
    endfunction

    function automatic exp_t flt_item(input logic [2:0] c, input logic [23:0] tag);
        exp_t e;
        e = '{is_fault: 1'b1, code: c, sel: 16'h0, eip: 32'h0, cpl: 2'd0, tag: tag};
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R11 actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; call_sel = '0; cpl = '0;
        gdt_base = GB; ldt_base = LB; rd_valid = 1'b0; rd_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: idle outputs after reset
        chk(busy == 0, "R12", {31'b0, busy}, 0);
        chk(done == 0, "R12", {31'b0, done}, 0);
        chk(fault == 0, "R12", {31'b0, fault}, 0);
        chk(rd_req == 0, "R12", {31'b0, rd_req}, 0);

        // descriptors
        put(16'h0028, 32'h0000_1234, hi_word(16'h004B, 1, 2'd3, 3'b101)); // gate g5 -> g9
        put(16'h0048, 32'h0020_0000, hi_word(16'h0000, 1, 2'd0, 3'b010)); // code g9 dpl0
        put(16'h003C, 32'h0000_2000, hi_word(16'h0054, 1, 2'd2, 3'b101)); // gate l7 -> l10
        put(16'h0054, 32'hFFFF_F000, hi_word(16'h0000, 1, 2'd1, 3'b010)); // code l10 dpl1
        put(16'h0030, 32'h0, hi_word(16'h0048, 1, 2'd3, 3'b010));         // g6 code, not gate
        put(16'h0038, 32'h0, hi_word(16'h0048, 0, 2'd3, 3'b101));         // g7 absent gate
        put(16'h0040, 32'h0, hi_word(16'h0048, 1, 2'd2, 3'b101));         // g8 gate dpl2
        put(16'h0050, 32'h0, hi_word(16'h0058, 1, 2'd3, 3'b101));         // g10 -> g11
        put(16'h0058, 32'h0, hi_word(16'h0000, 1, 2'd0, 3'b001));         // g11 data
        put(16'h0060, 32'h0, hi_word(16'h0068, 1, 2'd3, 3'b101));         // g12 -> g13
        put(16'h0068, 32'h0, hi_word(16'h0000, 0, 2'd0, 3'b010));         // g13 absent code
        put(16'h0070, 32'h0, hi_word(16'h0078, 1, 2'd3, 3'b101));         // g14 -> g15
        put(16'h0078, 32'h0, hi_word(16'h0000, 1, 2'd2, 3'b010));         // g15 code dpl2
        put(16'h0080, 32'h0, hi_word(16'h0048, 0, 2'd0, 3'b011));         // g16 bad kind+absent

        // R1 R2 R8 R9: global gate, level 3 enters level 0
        lat = 0;
        run(16'h0028, 2'd3, ok_item(16'h0048, 32'h0020_1234, 2'd0, "R9"));
        // R1 R8: local table, address wraps
        lat = 3;
        run(16'h003C, 2'd2, ok_item(16'h0055, 32'h0000_1000, 2'd1, "R1"));
        // R3 R4 R5
        lat = 1;
        run(16'h0030, 2'd0, flt_item(3'd1, "R3"));
        run(16'h0080, 2'd0, flt_item(3'd1, "R3"));
        run(16'h0038, 2'd0, flt_item(3'd2, "R4"));
        run(16'h0040, 2'd3, flt_item(3'd3, "R5"));
        run(16'h0043, 2'd0, flt_item(3'd3, "R5"));   // requested level 3 > gate dpl 2
        run(16'h0042, 2'd0, ok_item(16'h0048, 32'h0020_0000, 2'd0, "R5"));
        // R6 R7
        run(16'h0050, 2'd0, flt_item(3'd4, "R6"));
        run(16'h0060, 2'd0, flt_item(3'd5, "R6"));
        run(16'h0070, 2'd1, flt_item(3'd6, "R7"));
        run(16'h0070, 2'd2, ok_item(16'h007A, 32'h0, 2'd2, "R7"));

        // R11: a start while busy has no effect
        lat = 2;
        exp_q.push_back(ok_item(16'h0048, 32'h0020_1234, 2'd0, "R11"));
        @(negedge clk);
        call_sel = 16'h0028; cpl = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        call_sel = 16'h0030; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(busy == 0, "R11", {31'b0, busy}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule